// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single requests from a processor core into external bus machine cycles for an 8-bit data bus. The low address byte shares the data pins. A request gives a cycle kind, a 16-bit address and write data. The block first puts the low address byte on the shared pins and pulses an address-latch strobe. It then moves the pins to the data phase, asserts the read or write strobe and holds that phase for as long as the external target reports that it is not ready.

The sequencer drives a memory-or-I/O select line and a two-bit status code. Both stay steady for the whole machine cycle. For port accesses, the 8-bit port number is copied onto the upper address byte as well as the shared pins. When a cycle ends, the block returns a one-cycle completion pulse. For read cycles it also returns the byte it sampled from the bus.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is held and after it is released, the outputs are: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `{s1,s0}`=00, `io_m`=0, `rsp_done`=0 and `req_ready`=1.
- R2: A request with a legal kind is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle (T1), `ale` is high for exactly one cycle, `ad_oe` is 1 and `ad_out` carries the low address byte.
- R3: For I/O kinds, the port number `req_addr[7:0]` appears on `ad_out` in T1 and on `a_hi` for the whole cycle. For memory kinds, `a_hi` carries `req_addr[15:8]`. `a_hi` does not change within a cycle.
- R4: Kind codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. While a cycle is active, `{s1,s0}` is 11 for a fetch, 10 for either read and 01 for either write, and `io_m` is 1 only for kinds 3 and 4. Both hold steady from T1 to the last state.
- R5: `rd_n` (fetch and reads) or `wr_n` (writes) is low from T2 through T3, including any wait states. The two strobes are never low together. During a read strobe `ad_oe` is 0. During a write strobe `ad_oe` is 1 and `ad_out` carries the write data.
- R6: `ready` is sampled on the edge that ends T2 and on the edge that ends each wait state. Each low sample adds one wait state, so N low samples lengthen the strobe to 2+N cycles.
- R7: A fetch cycle has one decode state after T3, with both strobes high. A fetch therefore spans 4+N cycles from T1 to its last state, and every other kind spans 3+N.
- R8: Read data is taken from `ad_in` on the edge that ends T3. `rsp_done` pulses for one cycle, in the cycle after the last state. For reads, `rsp_rdata` holds the captured byte during that pulse.
- R9: `req_ready` is low from T1 to the last state. Requests presented in that time are ignored, and no extra cycle and no change of address follows.
- R10: A request with kind code 5, 6 or 7 is ignored. No `ale` follows it, and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core requests a machine cycle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Memory address or port number (low byte) |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read from the bus |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| a_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared address/data pins, driven value |
| ad_oe | output | 1 | Drive enable for the shared pins |
| ad_in | input | 8 | Shared address/data pins, sampled value |
| ready | input | 1 | Target ready; low inserts wait states |

## Verification
The embedded assertions check, on every cycle, the rules that hold whatever the stimulus. These are: the strobes are never low together, the shared pins are released under a read strobe, `ale` lasts a single cycle and follows an accepted legal request, a wait state comes only after a low `ready` sample, and the select and status lines hold steady within a cycle. Other behaviour can be shown only by the bench's scenarios against a memory model with a programmable number of wait states. This covers whether the latched address matches the request, whether a port number is copied correctly, the exact strobe and cycle lengths for a given wait count, the extra fetch state, the returned read data, and the dropping of requests made while busy or with undefined codes.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      K_FETCH = 3'd0,
      K_MRD   = 3'd1,
      K_MWR   = 3'd2,
      K_IORD  = 3'd3,
      K_IOWR  = 3'd4
   } bus_kind_e;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_TW   = 3'd3,
      PH_T3   = 3'd4,
      PH_T4   = 3'd5
   } bus_phase_e;

   typedef struct packed {
      logic is_io;
      logic is_wr;
      logic is_fetch;
   } kind_attr_t;

   function automatic logic kind_legal(input logic [KIND_W-1:0] k);
      return k <= K_IOWR;
   endfunction

   function automatic kind_attr_t kind_decode(input logic [KIND_W-1:0] k);
      kind_attr_t a;
      a.is_io    = (k == K_IORD) || (k == K_IOWR);
      a.is_wr    = (k == K_MWR)  || (k == K_IOWR);
      a.is_fetch = (k == K_FETCH);
      return a;
   endfunction
endpackage

// File: rtl/mbs_phase_ctl.sv
module mbs_phase_ctl
   import mbs_pkg::*;
#(
   parameter int DECODE_STATES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       is_fetch,
   input  logic       ready,
   output bus_phase_e phase,
   output logic       fin
);
   bus_phase_e phase_nx;
   logic       has_dec;
   logic       dec_last;

   generate
      if (DECODE_STATES == 0) begin : g_no_dec
         assign has_dec  = 1'b0;
         assign dec_last = 1'b1;
      end else begin : g_dec
         localparam int CW = (DECODE_STATES > 1) ? $clog2(DECODE_STATES) : 1;
         logic [CW-1:0] dcnt;
         always_ff @(posedge clk) begin
            if (!rst_n)              dcnt <= '0;
            else if (phase != PH_T4) dcnt <= '0;
            else                     dcnt <= dcnt + 1'b1;
         end
         assign has_dec  = 1'b1;
         assign dec_last = (dcnt == CW'(DECODE_STATES - 1));
      end
   endgenerate

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE: if (start) phase_nx = PH_T1;
         PH_T1:   phase_nx = PH_T2;
         PH_T2,
         PH_TW:   phase_nx = ready ? PH_T3 : PH_TW;
         PH_T3:   phase_nx = (is_fetch && has_dec) ? PH_T4 : PH_IDLE;
         PH_T4:   phase_nx = dec_last ? PH_IDLE : PH_T4;
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nx;
   end

   assign fin = ((phase == PH_T3) && !(is_fetch && has_dec)) ||
                ((phase == PH_T4) && dec_last);

   assert_wait_after_low_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TW) |-> (($past(phase) == PH_T2 || $past(phase) == PH_TW) && !$past(ready)));
   assert_t1_then_t2_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_T1) |=> (phase == PH_T2));
   assert_decode_only_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_T4) |-> is_fetch);
endmodule

// File: rtl/mbs_addr_stage.sv
module mbs_addr_stage
   import mbs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [KIND_W-1:0] req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  bus_phase_e        phase,
   output kind_attr_t        attr,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] addr_lo,
   output logic [DATA_W-1:0] a_hi,
   output logic              ale,
   output logic              io_m,
   output logic              s1,
   output logic              s0
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] addr_q;
   logic              busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         attr    <= '0;
      end else if (start) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         attr    <= kind_decode(req_kind);
      end
   end

   assign busy    = (phase != PH_IDLE);
   assign addr_lo = addr_q[DATA_W-1:0];
   assign ale     = (phase == PH_T1);
   assign io_m    = busy && attr.is_io;
   assign s1      = busy && !attr.is_wr;
   assign s0      = busy && (attr.is_wr || attr.is_fetch);

   always_comb begin
      if (!busy)            a_hi = '0;
      else if (attr.is_io)  a_hi = addr_q[DATA_W-1:0];
      else                  a_hi = addr_q[ADDR_W-1:ADDR_W-HI_W];
   end

   assert_status_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(phase) != PH_IDLE) |-> ($stable(io_m) && $stable(s1) && $stable(s0) && $stable(a_hi)));
   assert_status_coded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ({s1, s0} != 2'b00));
   assert_port_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ale && io_m) |-> (a_hi == addr_lo));
endmodule

// File: rtl/mbs_bus_drive.sv
module mbs_bus_drive
   import mbs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_phase_e        phase,
   input  logic              fin,
   input  logic              is_wr,
   input  logic [DATA_W-1:0] addr_lo,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic [DATA_W-1:0] ad_in,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);
   logic strobe;

   assign strobe = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
   assign rd_n   = !(strobe && !is_wr);
   assign wr_n   = !(strobe && is_wr);
   assign ad_oe  = (phase == PH_T1) || (strobe && is_wr);

   always_comb begin
      if (phase == PH_T1)       ad_out = addr_lo;
      else if (strobe && is_wr) ad_out = wdata_q;
      else                      ad_out = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         done  <= 1'b0;
      end else begin
         done <= fin;
         if ((phase == PH_T3) && !is_wr) rdata <= ad_in;
      end
   end

   assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   assert_released_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(phase) == PH_T3 || $past(phase) == PH_T4));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbs_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 16,
   parameter int DECODE_STATES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              io_m,
   output logic              s1,
   output logic              s0,
   output logic [DATA_W-1:0] a_hi,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   input  logic              ready
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("mux_bus_seq: ADDR_W must be twice DATA_W");
      end
      if (DECODE_STATES < 0 || DECODE_STATES > 15) begin : g_bad_decode
         $error("mux_bus_seq: DECODE_STATES out of range 0..15");
      end
   endgenerate

   bus_phase_e        phase;
   kind_attr_t        attr;
   logic              start;
   logic              fin;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] addr_lo;

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready && kind_legal(req_kind);

   mbs_phase_ctl #(.DECODE_STATES(DECODE_STATES)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_fetch (attr.is_fetch),
      .ready    (ready),
      .phase    (phase),
      .fin      (fin)
   );

   mbs_addr_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .req_kind  (req_kind),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .phase     (phase),
      .attr      (attr),
      .wdata_q   (wdata_q),
      .addr_lo   (addr_lo),
      .a_hi      (a_hi),
      .ale       (ale),
      .io_m      (io_m),
      .s1        (s1),
      .s0        (s0)
   );

   mbs_bus_drive #(.DATA_W(DATA_W)) u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase   (phase),
      .fin     (fin),
      .is_wr   (attr.is_wr),
      .addr_lo (addr_lo),
      .wdata_q (wdata_q),
      .ad_in   (ad_in),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .ad_out  (ad_out),
      .ad_oe   (ad_oe),
      .rdata   (rsp_rdata),
      .done    (rsp_done)
   );

   assert_ale_from_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> $past(req_valid && req_ready));
   assert_ale_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);
   assert_bad_kind_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && (req_kind > 3'd4)) |=> (!ale && req_ready));
endmodule

// File: tb/sim_mux_bus_seq.sv
module sim_mux_bus_seq;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_kind = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0] req_wdata = 8'h0;
   logic       req_ready, rsp_done, ale, rd_n, wr_n, io_m, s1, s0, ad_oe;
   logic [7:0] rsp_rdata, a_hi, ad_out, ad_in;
   logic       ready;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mux_bus_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ale(ale), .rd_n(rd_n),
      .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0), .a_hi(a_hi),
      .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ready(ready)
   );

   typedef struct {
      logic [2:0]  kind;
      logic [15:0] addr;
      logic [7:0]  wd;
      int          waits;
   } exp_t;
   exp_t sbq[$];
   int issued = 0;
   int ale_seen = 0;
   int done_seen = 0;

   function automatic logic [7:0] mem_byte(input logic [15:0] a, input logic io);
      return io ? (a[7:0] + 8'h11) : (a[7:0] ^ a[15:8] ^ 8'h3C);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Memory model: latches the bus address on ALE, holds READY low for a programmed count
   int          waits_cfg = 0;
   int          wcnt = 0;
   logic [15:0] lat_addr = 16'h0;
   logic        lat_io = 1'b0;
   always @(posedge clk) begin
      if (ale) begin
         wcnt     <= waits_cfg;
         lat_addr <= {a_hi, ad_out};
         lat_io   <= io_m;
      end else if ((!rd_n || !wr_n) && wcnt != 0) begin
         wcnt <= wcnt - 1;
      end
   end
   assign ready = (wcnt == 0);
   assign ad_in = !rd_n ? mem_byte(lat_addr, lat_io) : 8'hEE;

   // Driver: pushes the expected cycle and presents the request
   task automatic issue(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d, input int w);
      exp_t e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      waits_cfg = w;
      e.kind = k; e.addr = a; e.wd = d; e.waits = w;
      sbq.push_back(e);
      issued++;
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Monitor: observes the bus and compares each completed cycle with the queue head
   initial begin
      exp_t        cur;
      bit          trk = 0;
      int          len = 0, rdc = 0, wrc = 0;
      bit          wbad = 0, rbad = 0, hibad = 0, stbad = 0;
      logic [15:0] lad;
      logic [1:0]  st;
      logic        iom;
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         if (rsp_done) begin
            done_seen++;
            if (trk) begin
               automatic bit io  = (cur.kind == 3'd3) || (cur.kind == 3'd4);
               automatic bit wr  = (cur.kind == 3'd2) || (cur.kind == 3'd4);
               automatic bit fch = (cur.kind == 3'd0);
               automatic logic [15:0] ea = io ? {cur.addr[7:0], cur.addr[7:0]} : cur.addr;
               automatic logic [1:0]  es = fch ? 2'b11 : (wr ? 2'b01 : 2'b10);
               automatic int el = 3 + cur.waits + (fch ? 1 : 0);
               chk(lad == ea, io ? "R3 latched port address" : "R2 latched address", lad, ea);
               chk(st == es && !stbad, "R4 status code", st, es);
               chk(iom == io, "R4 io_m select", iom, io);
               chk(!hibad, "R3 upper byte steady", hibad, 0);
               chk(len == el, fch ? "R7 fetch cycle length" : "R6 cycle length", len, el);
               if (wr) begin
                  chk(wrc == 2 + cur.waits && rdc == 0, "R5 write strobe length", wrc, 2 + cur.waits);
                  chk(!wbad, "R5 write data on bus", wbad, 0);
               end else begin
                  chk(rdc == 2 + cur.waits && wrc == 0, "R6 read strobe length", rdc, 2 + cur.waits);
                  chk(!rbad, "R5 bus released in read", rbad, 0);
                  chk(rsp_rdata == mem_byte(ea, io), "R8 returned read data", rsp_rdata, mem_byte(ea, io));
               end
            end else begin
               chk(0, "R8 done without cycle", 1, 0);
            end
            trk = 0;
         end
         if (ale) begin
            ale_seen++;
            chk(ad_oe == 1'b1, "R2 ad_oe in T1", ad_oe, 1);
            if (sbq.size() == 0) begin
               chk(0, "R9 unexpected cycle", 1, 0);
               trk = 0;
            end else begin
               cur = sbq.pop_front();
               trk = 1; len = 0; rdc = 0; wrc = 0;
               wbad = 0; rbad = 0; hibad = 0; stbad = 0;
               lad = {a_hi, ad_out}; st = {s1, s0}; iom = io_m;
            end
         end
         if (trk) begin
            len++;
            if (a_hi != lad[15:8]) hibad = 1;
            if ({s1, s0} != st || io_m != iom) stbad = 1;
            if (!rd_n) begin rdc++; if (ad_oe) rbad = 1; end
            if (!wr_n) begin wrc++; if (!ad_oe || ad_out != cur.wd) wbad = 1; end
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(!ale && rd_n && wr_n && !ad_oe && !rsp_done && req_ready && {s1,s0} == 2'b00 && !io_m,
          "R1 reset outputs", {ale, rd_n, wr_n, ad_oe, rsp_done, req_ready, s1, s0, io_m}, 9'b0_1100_1000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ale && rd_n && wr_n && !ad_oe && req_ready, "R1 after release",
          {ale, rd_n, wr_n, ad_oe, req_ready}, 5'b01101);

      issue(3'd0, 16'h1234, 8'h00, 0);
      issue(3'd1, 16'hABCD, 8'h00, 2);
      issue(3'd2, 16'h00FF, 8'h5A, 0);
      issue(3'd3, 16'h337E, 8'h00, 1);
      issue(3'd4, 16'h0091, 8'hC3, 3);
      issue(3'd0, 16'h8001, 8'h00, 3);
      issue(3'd1, 16'h4242, 8'h00, 0);
      issue(3'd2, 16'hFE10, 8'h99, 1);
      issue(3'd3, 16'hFFFF, 8'h00, 0);
      issue(3'd0, 16'hFFFF, 8'h00, 0);

      // R9: requests presented while busy must be dropped
      issue(3'd1, 16'h2468, 8'h00, 4);
      req_valid = 1'b1; req_kind = 3'd4; req_addr = 16'h0F0F; req_wdata = 8'h11;
      repeat (3) begin
         chk(!req_ready, "R9 req_ready low while busy", req_ready, 0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(ale_seen == issued, "R9 no extra cycle after busy request", ale_seen, issued);

      // R10: undefined kind codes
      for (int k = 5; k < 8; k++) begin
         @(negedge clk);
         req_valid = 1'b1; req_kind = k[2:0]; req_addr = 16'h5555;
         @(negedge clk);
         req_valid = 1'b0;
         chk(!ale && req_ready, "R10 undefined kind ignored", {ale, req_ready}, 2'b01);
         @(negedge clk);
         chk(!ale && req_ready, "R10 still idle", {ale, req_ready}, 2'b01);
      end

      repeat (4) @(negedge clk);
      chk(sbq.size() == 0, "R8 all cycles completed", sbq.size(), 0);
      chk(done_seen == issued, "R8 done count", done_seen, issued);
      chk(ale_seen == issued, "R2 ale count", ale_seen, issued);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule